// File: doc/BRIEF.md
# Page-Buffered I2C Serial EEPROM Slave

This block is an I2C target that fronts a 256-byte storage array built from on-chip registers. It samples SCL and SDA with the system clock. It detects START and STOP conditions and decodes a select byte. That byte carries a fixed 4-bit prefix, three device bits and a direction bit. The block drives SDA only by asserting a pull-down enable, which suits an open-drain bus.

A write sequence has three parts: the select byte, one word-address byte, then data bytes. The data bytes collect in a 16-byte page buffer and reach the array only after the STOP that closes the sequence. Moving the buffer into the array takes a fixed number of clock cycles, set by a parameter. During that time the block ignores the bus and does not acknowledge its own select byte.

Writes are refused when the write-protect input is high or when the supply-ok flag is low. A refused sequence still acknowledges every byte, but it starts no write cycle and leaves the array unchanged.

Reads can start from a new address (random read), or from the address that follows the last byte touched (current-address read). Either kind can continue byte after byte (sequential read) until the controller answers with a NACK.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A select byte is acknowledged only if its top nibble is 1010 and bits 3..1 equal the DEV_SEL parameter (default 000). A mismatching select byte is not acknowledged, and all later bytes are ignored until the next START.
- R2: After a select byte with bit 0 = 0 (write), the next byte is acknowledged and loaded as the word address.
- R3: Data bytes of a write sequence are acknowledged and held in the page buffer. They appear in the array once the write cycle that follows STOP has finished.
- R4: During a page write, the low 4 address bits step up and wrap inside the 16-byte page. The 17th byte overwrites the slot the 1st byte used, and the upper 4 address bits never change.
- R5: For WRITE_CYCLES clocks after a STOP that starts a write cycle, the block does not acknowledge a select byte and keeps SDA released.
- R6: With wp_in high (and WP support enabled, the default), a write sequence still acknowledges its bytes, starts no write cycle, and leaves the array unchanged. The next select byte is acknowledged at once.
- R7: With supply_ok low, a write sequence behaves exactly as in R6.
- R8: A random read is a write select byte, a word address, a repeated START and then a read select byte (bit 0 = 1). It returns the byte stored at that word address.
- R9: A current-address read returns the byte that follows the last byte read or written.
- R10: A sequential read steps the address across the full array and wraps from 0xFF to 0x00. A NACK from the controller ends the read with SDA released.
- R11: After reset, SDA is released, every array byte reads 0xFF, and the current address is 0.
- R12: The SDA pull-down enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired line) |
| wp_in | input | 1 | Write protect, high blocks writes |
| supply_ok | input | 1 | High while the supply is above its threshold |
| sda_pull | output | 1 | Pull-down enable for the SDA line |

## Verification
The in-RTL assertions check three things on every clock. First, SDA is never pulled while a write cycle runs. Second, a write cycle never begins when write-protect was high or the supply was low on the cycle before. Third, the pull-down enable holds steady through every SCL high phase, and no new commit is requested while one is in progress.

Some properties are visible only at the bus, so the bench scenarios cover them. These are: the in-page address wrap, the full-array wrap of sequential reads, the address carried over into a current-address read, the array left untouched by refused writes, and the data that reaches the array. A behavioural model of the array and of the busy window checks each of these.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SELECT,
      PH_WORD,
      PH_WDATA,
      PH_RDATA
   } bus_phase_t;

   localparam logic [3:0] SEL_PREFIX = 4'b1010;
   localparam int         BYTE_W     = 8;
endpackage

// File: rtl/eeprom_bus_sync.sv
module eeprom_bus_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int TAP = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("eeprom_bus_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES:0] scl_sr, sda_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sr <= '1;
         sda_sr <= '1;
      end else begin
         scl_sr <= {scl_sr[SYNC_STAGES-1:0], scl_in};
         sda_sr <= {sda_sr[SYNC_STAGES-1:0], sda_in};
      end
   end

   logic scl_prev, sda_prev;
   assign scl_lvl   = scl_sr[TAP];
   assign sda_lvl   = sda_sr[TAP];
   assign scl_prev  = scl_sr[SYNC_STAGES];
   assign sda_prev  = sda_sr[SYNC_STAGES];
   assign scl_rise  = scl_lvl & ~scl_prev;
   assign scl_fall  = ~scl_lvl & scl_prev;
   assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
   parameter int           ADDR_W       = 8,
   parameter int           PAGE_W       = 4,
   parameter int           DATA_W       = 8,
   parameter int           WRITE_CYCLES = 4000,
   parameter logic [7:0]   ERASED       = 8'hFF
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     buf_clear,
   input  logic                     buf_wr,
   input  logic [PAGE_W-1:0]        buf_slot,
   input  logic [DATA_W-1:0]        buf_data,
   input  logic                     commit_req,
   input  logic [ADDR_W-PAGE_W-1:0] commit_page,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     busy
);
   localparam int DEPTH      = 1 << ADDR_W;
   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam int CNT_W      = $clog2(WRITE_CYCLES + 1);

   generate
      if (PAGE_W >= ADDR_W) begin : g_bad_page
         $error("eeprom_store: page must be smaller than the array");
      end
      if (WRITE_CYCLES < 1) begin : g_bad_wcyc
         $error("eeprom_store: WRITE_CYCLES must be positive");
      end
   endgenerate

   logic [DATA_W-1:0]        mem  [DEPTH];
   logic [DATA_W-1:0]        pbuf [PAGE_BYTES];
   logic [PAGE_BYTES-1:0]    pvalid;
   logic [ADDR_W-PAGE_W-1:0] page_q;
   logic [CNT_W-1:0]         cnt;
   logic                     busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
         for (int s = 0; s < PAGE_BYTES; s++) pbuf[s] <= '0;
         pvalid <= '0;
         page_q <= '0;
         cnt    <= '0;
         busy_q <= 1'b0;
      end else begin
         if (buf_clear) pvalid <= '0;
         else if (buf_wr) begin
            pbuf[buf_slot]   <= buf_data;
            pvalid[buf_slot] <= 1'b1;
         end
         if (commit_req && !busy_q) begin
            busy_q <= 1'b1;
            page_q <= commit_page;
            cnt    <= CNT_W'(WRITE_CYCLES - 1);
         end else if (busy_q) begin
            if (cnt == '0) begin
               busy_q <= 1'b0;
               pvalid <= '0;
               for (int s = 0; s < PAGE_BYTES; s++)
                  if (pvalid[s]) mem[{page_q, PAGE_W'(s)}] <= pbuf[s];
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   assign rd_data = mem[rd_addr];
   assign busy    = busy_q;

   AST_NO_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |-> !busy_q); // R5
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
   import eeprom_pkg::*;
#(
   parameter logic [2:0] DEV_SEL      = 3'b000,
   parameter int         ADDR_W       = 8,
   parameter int         PAGE_W       = 4,
   parameter int         WRITE_CYCLES = 4000,
   parameter bit         HAS_WP       = 1'b1,
   parameter int         SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   input  logic wp_in,
   input  logic supply_ok,
   output logic sda_pull
);
   localparam int HI_W = ADDR_W - PAGE_W;

   generate
      if (ADDR_W > BYTE_W) begin : g_bad_addr
         $error("eeprom_i2c_slave: one word-address byte must cover the array");
      end
   endgenerate

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

   eeprom_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
   );

   logic write_lock;
   generate
      if (HAS_WP) begin : g_wp
         assign write_lock = wp_in | ~supply_ok;
         AST_WP_BLOCKS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy) |-> !$past(wp_in)); // R6
      end else begin : g_no_wp
         logic unused_wp;
         assign unused_wp  = wp_in;
         assign write_lock = ~supply_ok;
      end
   endgenerate

   bus_phase_t             phase;
   logic [3:0]             rcnt;
   logic [BYTE_W-1:0]      shreg, txbyte;
   logic [ADDR_W-1:0]      addr;
   logic                   pull_q, got_data, busy;
   logic [BYTE_W-1:0]      rd_data;
   logic [2:0]             tx_idx;
   logic                   ack_slot, sel_match;

   assign ack_slot  = scl_fall && (rcnt == 4'd8);
   assign sel_match = (shreg[7:4] == SEL_PREFIX) && (shreg[3:1] == DEV_SEL) && !busy;
   assign tx_idx    = 3'(4'd7 - rcnt);

   logic buf_clear, buf_wr, commit_req;
   assign buf_clear  = ack_slot && (phase == PH_WORD);
   assign buf_wr     = ack_slot && (phase == PH_WDATA);
   assign commit_req = stop_det && (phase == PH_WDATA) && got_data && !write_lock && !busy;

   eeprom_store #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(BYTE_W), .WRITE_CYCLES(WRITE_CYCLES)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .buf_clear(buf_clear), .buf_wr(buf_wr),
      .buf_slot(addr[PAGE_W-1:0]), .buf_data(shreg),
      .commit_req(commit_req), .commit_page(addr[ADDR_W-1:PAGE_W]),
      .rd_addr(addr), .rd_data(rd_data), .busy(busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         rcnt     <= '0;
         shreg    <= '0;
         txbyte   <= '0;
         addr     <= '0;
         pull_q   <= 1'b0;
         got_data <= 1'b0;
      end else if (stop_det) begin
         phase    <= PH_IDLE;
         pull_q   <= 1'b0;
         got_data <= 1'b0;
      end else if (start_det) begin
         phase    <= PH_SELECT;
         rcnt     <= '0;
         pull_q   <= 1'b0;
         got_data <= 1'b0;
      end else if (phase != PH_IDLE) begin
         if (scl_rise) begin
            if (rcnt != 4'd9) rcnt <= rcnt + 1'b1;
            if (rcnt < 4'd8) shreg <= {shreg[BYTE_W-2:0], sda_lvl};
            if (rcnt == 4'd8 && phase == PH_RDATA && sda_lvl) phase <= PH_IDLE;
         end
         if (scl_fall) begin
            if (rcnt == 4'd8) begin
               unique case (phase)
                  PH_SELECT: begin
                     if (sel_match) begin
                        pull_q <= 1'b1;
                        phase  <= shreg[0] ? PH_RDATA : PH_WORD;
                     end else begin
                        phase  <= PH_IDLE;
                     end
                  end
                  PH_WORD: begin
                     pull_q <= 1'b1;
                     addr   <= shreg[ADDR_W-1:0];
                     phase  <= PH_WDATA;
                  end
                  PH_WDATA: begin
                     pull_q   <= 1'b1;
                     got_data <= 1'b1;
                     addr     <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
                  end
                  PH_RDATA: begin
                     pull_q <= 1'b0;
                     addr   <= addr + 1'b1;
                  end
                  default: ;
               endcase
            end else if (rcnt == 4'd9) begin
               rcnt <= '0;
               if (phase == PH_RDATA) begin
                  txbyte <= rd_data;
                  pull_q <= ~rd_data[BYTE_W-1];
               end else begin
                  pull_q <= 1'b0;
               end
            end else if (phase == PH_RDATA && rcnt != 4'd0) begin
               pull_q <= ~txbyte[tx_idx];
            end
         end
      end
   end

   assign sda_pull = pull_q;

   AST_DEAF_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_pull); // R5
   AST_SUPPLY_BLOCKS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(supply_ok)); // R7
   AST_PULL_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && $past(scl_lvl)) |-> $stable(sda_pull)); // R12
endmodule

// File: tb/eeprom_i2c_slave_tb.sv
`timescale 1ns/1ps
module eeprom_i2c_slave_tb;
   localparam int WCYC  = 2000;
   localparam int QTR   = 5;
   localparam int LIMIT = 150000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl = 1'b1, m_sda = 1'b1, wp = 1'b0, sup = 1'b1;
   logic sda_pull, sda_line;
   assign sda_line = m_sda & ~sda_pull;

   always #2.5 clk = ~clk;

   eeprom_i2c_slave #(.WRITE_CYCLES(WCYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
      .wp_in(wp), .supply_ok(sup), .sda_pull(sda_pull)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   int ref_mem [256];
   int ref_addr = 0;
   int busy_from = -1, busy_to = -1;
   logic prev_scl = 1'b1, prev_pull = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // per-clock model comparison and watchdog
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (cyc >= busy_from && cyc <= busy_to)
            chk(sda_pull == 1'b0, "R5 released during write cycle", sda_pull, 0);
         if (scl && prev_scl)
            chk(sda_pull == prev_pull, "R12 pull stable while SCL high", sda_pull, prev_pull);
      end
      prev_scl  = scl;
      prev_pull = sda_pull;
      if (cyc == LIMIT) begin
         chk(1'b0, "watchdog", cyc, LIMIT);
         summary();
      end
   end

   task automatic q(); repeat (QTR) @(negedge clk); endtask

   task automatic bus_start();
      m_sda = 1'b1; q(); scl = 1'b1; q(); m_sda = 1'b0; q(); scl = 1'b0; q();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; q(); scl = 1'b1; q(); m_sda = 1'b1; q(); q();
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
      end
      m_sda = 1'b1; q(); scl = 1'b1; q();
      acked = ~sda_line;
      q(); scl = 1'b0; q();
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         q(); scl = 1'b1; q(); b[i] = sda_line; q(); scl = 1'b0;
      end
      q(); m_sda = give_ack ? 1'b0 : 1'b1; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
      m_sda = 1'b1;
   endtask

   // write sequence with model update; expects every byte acknowledged
   task automatic wr_seq(input int a, input int n, input int seed, input string req);
      bit ack;
      bit pv [16];
      int pd [16];
      bit blocked = wp | ~sup;
      for (int s = 0; s < 16; s++) pv[s] = 0;
      bus_start();
      send_byte(8'hA0, ack); chk(ack, {req, " select ack"}, ack, 1);
      send_byte(8'(a), ack); chk(ack, "R2 word address ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         int v = (seed + i * 37) & 8'hFF;
         int slot = (a + i) & 15;
         send_byte(8'(v), ack); chk(ack, {req, " data ack"}, ack, 1);
         pv[slot] = 1; pd[slot] = v;
      end
      ref_addr = (a & 8'hF0) | ((a + n) & 15);
      bus_stop();
      if (!blocked) begin
         busy_from = cyc + 8;
         busy_to   = cyc + WCYC - 8;
         for (int s = 0; s < 16; s++) if (pv[s]) ref_mem[(a & 8'hF0) | s] = pd[s];
         bus_start();
         send_byte(8'hA0, ack); chk(!ack, "R5 select not acked while busy", ack, 0);
         bus_stop();
         repeat (WCYC + 40) @(negedge clk);
      end else begin
         bus_start();
         send_byte(8'hA0, ack); chk(ack, {req, " no write cycle started"}, ack, 1);
         bus_stop();
      end
   endtask

   task automatic rd_seq(input bit random, input int a, input int n, input string req);
      bit ack;
      logic [7:0] b;
      if (random) begin
         bus_start();
         send_byte(8'hA0, ack); chk(ack, {req, " write select ack"}, ack, 1);
         send_byte(8'(a), ack); chk(ack, "R2 word address ack", ack, 1);
         ref_addr = a;
      end
      bus_start();
      send_byte(8'hA1, ack); chk(ack, {req, " read select ack"}, ack, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n - 1, b);
         chk(b == 8'(ref_mem[ref_addr]), req, b, ref_mem[ref_addr]);
         ref_addr = (ref_addr + 1) & 8'hFF;
      end
      chk(sda_pull == 1'b0, "R10 released after NACK", sda_pull, 0);
      bus_stop();
   endtask

   initial begin
      bit ack;
      for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      q();
      chk(sda_pull == 1'b0, "R11 SDA released after reset", sda_pull, 0);
      // R11: current-address read from address 0 returns erased value
      rd_seq(1'b0, 0, 2, "R11 erased contents");

      // R1: wrong prefix and wrong device bits
      bus_start();
      send_byte(8'hB0, ack); chk(!ack, "R1 prefix mismatch not acked", ack, 0);
      send_byte(8'h00, ack); chk(!ack, "R1 later byte ignored", ack, 0);
      bus_stop();
      bus_start();
      send_byte(8'hA2, ack); chk(!ack, "R1 device bits mismatch not acked", ack, 0);
      bus_stop();

      // R3 page write, R8 random read back
      wr_seq(8'h20, 5, 8'h11, "R3");
      rd_seq(1'b1, 8'h20, 5, "R8 random read of page write");

      // R4 wrap within page
      wr_seq(8'h3E, 18, 8'h40, "R4");
      rd_seq(1'b1, 8'h30, 16, "R4 page wrap contents");

      // R6 write protect
      wp = 1'b1;
      wr_seq(8'h50, 3, 8'h99, "R6");
      wp = 1'b0;
      rd_seq(1'b1, 8'h50, 3, "R6 array unchanged");

      // R7 supply low
      sup = 1'b0;
      wr_seq(8'h60, 4, 8'h77, "R7");
      sup = 1'b1;
      rd_seq(1'b1, 8'h60, 4, "R7 array unchanged");

      // R9 current-address read continues after random read
      wr_seq(8'h70, 3, 8'h05, "R3");
      rd_seq(1'b1, 8'h70, 1, "R8 single byte");
      rd_seq(1'b0, 0, 2, "R9 current-address read");
      // R9 after a page write: next address in page
      wr_seq(8'h84, 2, 8'hC3, "R3");
      rd_seq(1'b0, 0, 1, "R9 after write");

      // R10 sequential read wraps 0xFF -> 0x00
      wr_seq(8'hFE, 2, 8'h5A, "R3");
      rd_seq(1'b1, 8'hFE, 3, "R10 full-array wrap");

      summary();
   end
endmodule